// File: doc/BRIEF.md
# Checked serial command receiver

This block is the receive side of a serial slave that sets the outputs and configuration of a multi-channel output driver. A controller lowers chip-select, shifts a command word in on the data line, most significant bit first, on rising serial clock edges, and raises chip-select again. The command word is 8 or 16 bits wide, chosen by a static width input. When the checking input is high, an 8-bit check byte must follow the word. The check byte is a constant 1 marker bit followed by a 7-bit CRC. The block runs this CRC over the word and the marker bit, and compares it with the received value.

The three serial pins are brought into the system clock domain through a synchroniser, and the serial clock is oversampled there. Each transaction is judged once, when the synchronised chip-select rises. The block counts clock pulses, checks the frame length and checks the CRC. The command is written to the held command register only if every test passes. A count that is not a multiple of 8 raises the count-error flag and pulls the active-low fault pin. A CRC failure raises the CRC-error flag and pulls the active-low error pin. The flags stay visible until the next transaction has been judged, so they can be reported in that transaction.

The command leaves the block as a held register with a one-cycle strobe that marks each commit. No ready input exists and the block applies no back-pressure. Whatever consumes the register must accept every strobe, and it always finds the latest committed word in the register.

Top module: `spi_cmd_rx`

## Requirements
- R1: During and after reset, `cmd_q` is 0, `cmd_valid` is 0, both error flags are 0, and `crc_err_n` and `fault_n` are 1.
- R2: The CRC is 7 bits wide and uses the polynomial x^7+x^5+x^4+x^2+x+1 (feedback mask 0x37). It is preset to 0x7F at every chip-select fall and shifted one received bit at a time, MSB first. It covers the data bits plus the marker bit, which is 9 bits for narrow frames and 17 bits for wide frames.
- R3: With `crc_en`=1, a frame is committed when it has exactly the data width plus 8 clocks, its marker bit (the first check bit) is 1, and its last 7 bits equal the CRC, sent MSB first so that the LSB comes last.
- R4: With `crc_en`=0, a frame of exactly the data width in clocks is committed without any check.
- R5: Data arrives MSB first. With `wide_mode`=1, a commit writes all 16 bits of `cmd_q`. With `wide_mode`=0, it writes `cmd_q[7:0]` from the 8 data bits and leaves `cmd_q[15:8]` unchanged.
- R6: With checking enabled and a correct clock count, a CRC mismatch or a marker bit of 0 leaves `cmd_q` unchanged, sets `crc_err_flag` to 1 and drives `crc_err_n` to 0.
- R7: A clock count that is not a multiple of 8 leaves `cmd_q` unchanged, sets `cnt_err_flag` to 1, drives `fault_n` to 0 and clears `crc_err_flag`. A count of 255 or more is treated as not a multiple of 8.
- R8: A clock count that is a multiple of 8 (including 0) but differs from the expected frame length leaves `cmd_q` unchanged and clears both flags.
- R9: A judged frame's effect on `cmd_q`, `cmd_valid` and the flags appears on the third system clock edge after the chip-select pin rises (synchroniser depth plus one). `cmd_valid` is high for that one cycle on a commit only.
- R10: The flags change only when a frame is judged. A committed frame clears both flags.
- R11: Serial clock edges while chip-select is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_cs_n | input | 1 | Active-low chip-select |
| spi_mosi | input | 1 | Serial data from the controller |
| crc_en | input | 1 | Static: 1 expects a check byte and checks the CRC |
| wide_mode | input | 1 | Static: 1 for 16-bit commands, 0 for 8-bit |
| cmd_q | output | 16 | Committed command register |
| cmd_valid | output | 1 | One-cycle strobe on each commit |
| crc_err_flag | output | 1 | Last judged frame failed its CRC or marker test |
| crc_err_n | output | 1 | Active-low copy of the CRC-error flag |
| cnt_err_flag | output | 1 | Last judged frame had a clock count not a multiple of 8 |
| fault_n | output | 1 | Active-low copy of the count-error flag |

## Verification
Every result of this block is due on one fixed edge: the third system clock edge after the bench raises chip-select. That edge comes from two synchroniser stages plus the output register. When the bench raises chip-select, its reference model records the current cycle number and queues the expected register and flag values for that cycle plus three. On every falling clock edge it retires the queued entry whose cycle has come and compares all six outputs, so a strobe that comes early, comes late or lasts more than one cycle is a mismatch. The per-frame checks wait well past the due edge before they read the held outputs.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int          CRC_W    = 7;
  localparam int          CHK_W    = CRC_W + 1;  // marker + FCS
  localparam logic [6:0]  CRC_POLY = 7'h37;      // x^5+x^4+x^2+x+1 terms
  localparam logic [6:0]  CRC_INIT = 7'h7F;

  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c,
                                                  input logic d);
    logic fb;
    fb = c[CRC_W-1] ^ d;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/crc7_serial.sv
module crc7_serial
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= CRC_INIT;
    else if (init) crc <= CRC_INIT;
    else if (en)   crc <= crc7_step(crc, din);
  end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_cmd_pkg::*;
#(
  parameter int SHIFT_W = 24,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,     // chip-select fell
  input  logic               bit_en,    // serial clock rose while selected
  input  logic               bit_in,
  input  logic [CNT_W-1:0]   crc_len,   // bits covered by the CRC
  output logic [CNT_W-1:0]   bit_cnt,
  output logic [SHIFT_W-1:0] shreg,
  output logic [CRC_W-1:0]   crc
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic crc_take;
  assign crc_take = bit_en && (bit_cnt < crc_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (start) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (bit_en) begin
      shreg <= {shreg[SHIFT_W-2:0], bit_in};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  crc7_serial u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .init (start),
    .en   (crc_take),
    .din  (bit_in),
    .crc  (crc)
  );
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int NARROW_W    = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              crc_en,
  input  logic              wide_mode,
  output logic [DATA_W-1:0] cmd_q,
  output logic              cmd_valid,
  output logic              crc_err_flag,
  output logic              crc_err_n,
  output logic              cnt_err_flag,
  output logic              fault_n
);
  localparam int SHIFT_W = DATA_W + CHK_W;

  // synchronised pins: {sck, cs_n, mosi}
  logic [2:0] pins_s;
  logic       sck_s, cs_s, mosi_s, sck_d, cs_d;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({spi_sck, spi_cs_n, spi_mosi}),
    .q    (pins_s)
  );
  assign {sck_s, cs_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  logic frame_start, frame_end, bit_en;
  assign frame_start = cs_d & ~cs_s;
  assign frame_end   = ~cs_d & cs_s;
  assign bit_en      = sck_s & ~sck_d & ~cs_s;

  logic [CNT_W-1:0] data_len, frame_len, crc_len;
  assign data_len  = wide_mode ? CNT_W'(DATA_W) : CNT_W'(NARROW_W);
  assign frame_len = data_len + (crc_en ? CNT_W'(CHK_W) : '0);
  assign crc_len   = data_len + CNT_W'(1);

  logic [CNT_W-1:0]   bit_cnt;
  logic [SHIFT_W-1:0] shreg;
  logic [CRC_W-1:0]   crc_calc;

  spi_frame_rx #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (frame_start),
    .bit_en (bit_en),
    .bit_in (mosi_s),
    .crc_len(crc_len),
    .bit_cnt(bit_cnt),
    .shreg  (shreg),
    .crc    (crc_calc)
  );

  // frame judgement
  logic              cnt_bad, len_ok, chk_bad, commit;
  logic [DATA_W-1:0] data_word, cmd_next;

  assign cnt_bad   = bit_cnt[2:0] != 3'd0;
  assign len_ok    = bit_cnt == frame_len;
  assign chk_bad   = crc_en && ((crc_calc != shreg[CRC_W-1:0]) || !shreg[CRC_W]);
  assign commit    = frame_end && !cnt_bad && len_ok && !chk_bad;
  assign data_word = crc_en ? shreg[CHK_W +: DATA_W] : shreg[DATA_W-1:0];
  assign cmd_next  = wide_mode ? data_word
                               : {cmd_q[DATA_W-1:NARROW_W], data_word[NARROW_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q        <= '0;
      cmd_valid    <= 1'b0;
      crc_err_flag <= 1'b0;
      cnt_err_flag <= 1'b0;
    end else begin
      cmd_valid <= commit;
      if (commit) cmd_q <= cmd_next;
      if (frame_end) begin
        cnt_err_flag <= cnt_bad;
        crc_err_flag <= !cnt_bad && len_ok && chk_bad;
      end
    end
  end

  assign crc_err_n = ~crc_err_flag;
  assign fault_n   = ~cnt_err_flag;
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] cmd_q,
  input logic              cmd_valid,
  input logic              crc_err_flag,
  input logic              cnt_err_flag,
  input logic              fault_n,
  input logic              frame_end
);
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R9
  valid_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(frame_end));

  // R3
  cmd_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_q) |-> cmd_valid);

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(crc_err_flag && cnt_err_flag));

  // R6
  commit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (!crc_err_flag && !cnt_err_flag));

  // R10
  flag_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(crc_err_flag) || !$stable(cnt_err_flag)) |-> $past(frame_end));

  // R7
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> $stable(cmd_q));
endmodule

bind spi_cmd_rx spi_cmd_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_q       (cmd_q),
  .cmd_valid   (cmd_valid),
  .crc_err_flag(crc_err_flag),
  .cnt_err_flag(cnt_err_flag),
  .fault_n     (fault_n),
  .frame_end   (frame_end)
);

// File: tb/tb_spi_cmd_rx.sv
module tb_spi_cmd_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic crc_en = 1'b0, wide_mode = 1'b1;
  logic [15:0] cmd_q;
  logic cmd_valid, crc_err_flag, crc_err_n, cnt_err_flag, fault_n;

  always #10 clk = ~clk;  // 50 MHz

  spi_cmd_rx dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .crc_en(crc_en), .wide_mode(wide_mode),
    .cmd_q(cmd_q), .cmd_valid(cmd_valid), .crc_err_flag(crc_err_flag),
    .crc_err_n(crc_err_n), .cnt_err_flag(cnt_err_flag), .fault_n(fault_n)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit live = 0, done = 0;

  // reference model state
  logic [15:0] m_cmd = '0;
  logic [15:0] e_cmd = '0;
  logic e_valid = 0, e_crc = 0, e_cnt = 0;
  int   q_at[$];
  logic [18:0] q_val[$];   // {commit, crc_err, cnt_err, cmd}
  bit   fbits[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (live) begin
      e_valid = 0;
      if (q_at.size() > 0 && q_at[0] == cyc) begin
        logic [18:0] v;
        v = q_val.pop_front();
        void'(q_at.pop_front());
        e_valid = v[18]; e_crc = v[17]; e_cnt = v[16]; e_cmd = v[15:0];
      end
      check("R9", "cmd_q", cmd_q, e_cmd);
      check("R9", "cmd_valid", cmd_valid, e_valid);
      check("R6", "crc_err_flag", crc_err_flag, e_crc);
      check("R6", "crc_err_n", crc_err_n, !e_crc);
      check("R7", "cnt_err_flag", cnt_err_flag, e_cnt);
      check("R7", "fault_n", fault_n, !e_cnt);
    end
  end

  function automatic logic [6:0] ref_crc(input int nb);
    logic [6:0] c = 7'h7F;
    for (int i = 0; i < nb; i++) begin
      logic fb = c[6] ^ fbits[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h37;
    end
    return c;
  endfunction

  // build frame: ndata data bits MSB first, optional check byte
  task automatic build(input logic [15:0] d, input int ndata, input bit chk,
                       input bit marker, input bit flip);
    logic [6:0] f;
    fbits.delete();
    for (int i = ndata - 1; i >= 0; i--) fbits.push_back(d[i]);
    if (chk) begin
      fbits.push_back(marker);
      f = ref_crc(ndata + 1);
      if (flip) f[0] = ~f[0];
      for (int i = 6; i >= 0; i--) fbits.push_back(f[i]);
    end
  endtask

  task automatic model_end(input int at);
    int n = fbits.size();
    int dw = wide_mode ? 16 : 8;
    int el = dw + (crc_en ? 8 : 0);
    bit com = 0, ce = 0, ke = 0;
    logic [15:0] d = '0;
    logic [6:0] rx;
    if (n % 8 != 0 || n >= 255) ke = 1;
    else if (n == el) begin
      if (crc_en) begin
        for (int i = 0; i < 7; i++) rx[6-i] = fbits[dw + 1 + i];
        ce = (ref_crc(dw + 1) != rx) || (fbits[dw] == 1'b0);
      end
      if (!ce) begin
        com = 1;
        for (int i = 0; i < dw; i++) d = {d[14:0], fbits[i]};
        if (wide_mode) m_cmd = d; else m_cmd[7:0] = d[7:0];
      end
    end
    q_at.push_back(at);
    q_val.push_back({com, ce, ke, m_cmd});
  endtask

  task automatic send_frame();
    @(negedge clk); spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    foreach (fbits[i]) begin
      spi_mosi = fbits[i];
      repeat (4) @(negedge clk); spi_sck = 1'b1;
      repeat (4) @(negedge clk); spi_sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    model_end(cyc + 3);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "cmd_q", cmd_q, 0);
    check("R1", "cmd_valid", cmd_valid, 0);
    check("R1", "flags", {crc_err_flag, cnt_err_flag}, 0);
    check("R1", "pins", {crc_err_n, fault_n}, 3);
    rst_n = 1'b1;
    live = 1;
    repeat (4) @(negedge clk);

    // R3 R2: wide checked frame
    crc_en = 1; wide_mode = 1;
    build(16'hA5C3, 16, 1, 1, 0); send_frame();
    check("R3", "wide checked commit", cmd_q, 16'hA5C3);

    // R6: bad FCS (LSB flipped)
    build(16'h1234, 16, 1, 1, 1); send_frame();
    check("R6", "cmd kept on crc error", cmd_q, 16'hA5C3);
    check("R6", "crc_err_n low", crc_err_n, 0);

    // R10: good frame clears flag
    build(16'h0F0F, 16, 1, 1, 0); send_frame();
    check("R10", "crc flag cleared", crc_err_flag, 0);
    check("R2", "cmd after good", cmd_q, 16'h0F0F);

    // R6: marker 0 with CRC computed over it
    build(16'h7777, 16, 1, 0, 0); send_frame();
    check("R6", "marker zero rejected", {crc_err_flag, cmd_q}, {1'b1, 16'h0F0F});

    // R4: unchecked wide
    crc_en = 0;
    build(16'hBEEF, 16, 0, 0, 0); send_frame();
    check("R4", "unchecked commit", cmd_q, 16'hBEEF);

    // R5: narrow unchecked keeps upper byte
    wide_mode = 0;
    build(16'h005A, 8, 0, 0, 0); send_frame();
    check("R5", "narrow unchecked", cmd_q, 16'hBE5A);

    // R5 R3: narrow checked
    crc_en = 1;
    build(16'h003C, 8, 1, 1, 0); send_frame();
    check("R5", "narrow checked", cmd_q, 16'hBE3C);

    // R7: 12 clocks
    build(16'h0ABC, 12, 0, 0, 0); send_frame();
    check("R7", "count error", {cnt_err_flag, fault_n, cmd_q}, {2'b10, 16'hBE3C});

    // R8: wide checked mode but only 16 clocks
    wide_mode = 1;
    build(16'hDEAD, 16, 0, 0, 0); send_frame();
    check("R8", "length mismatch ignored", {cnt_err_flag, crc_err_flag, cmd_q}, {2'b00, 16'hBE3C});

    // R8: zero clocks
    fbits.delete(); send_frame();
    check("R8", "empty frame ignored", cmd_q, 16'hBE3C);

    // R11: clocks while deselected, then a clean frame
    crc_en = 0;
    for (int k = 0; k < 5; k++) begin
      spi_mosi = k[0];
      repeat (4) @(negedge clk); spi_sck = 1'b1;
      repeat (4) @(negedge clk); spi_sck = 1'b0;
    end
    check("R11", "no effect while deselected", cmd_q, 16'hBE3C);
    build(16'h1357, 16, 0, 0, 0); send_frame();
    check("R11", "next frame counts clean", {cnt_err_flag, cmd_q}, {1'b0, 16'h1357});

    repeat (5) @(negedge clk);
    live = 0;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule